// File: doc/BRIEF.md
# Byte-Wide Link Port with Word Packing

This block is one end of a point-to-point byte link between two devices. A single configuration input sets the port as a transmitter or as a receiver. As a transmitter it takes whole words from a valid/ready word interface, keeps up to two of them, and sends them over the link one byte per cycle, least significant byte first. As a receiver it collects link bytes into words and offers the finished words on a valid/ready word interface, with up to two complete words held.

A second configuration input picks the word width. A narrow word is 32 bits and takes four byte transfers. A wide word is 48 bits and takes six. The sender raises a one-cycle strobe with each byte. The receiver raises an acknowledge while it has room for more. The sender only strobes in a cycle when it sees acknowledge high. Changing either configuration input throws away all partial and buffered state.

Top module: `lp_link_port`

## Requirements
- R1: `lnk_stb_out` is high only in a cycle where the port is a transmitter, holds at least one buffered word and sees `lnk_ack_in` high. Each strobe cycle carries exactly one byte on `lnk_dat_out`.
- R2: When `cfg_wide` is 0, each word is carried as 4 bytes, bits [7:0] first and bits [31:24] last. `wr_data[47:32]` is ignored, and `rd_data[47:32]` reads zero.
- R3: When `cfg_wide` is 1, each word is carried as 6 bytes, bits [7:0] first and bits [47:40] last.
- R4: A receiving port holds `lnk_ack_out` high while fewer than two complete words are waiting to be read, and low while two are waiting.
- R5: A transmitting port holds `wr_ready` low while it holds two words that are not fully sent.
- R6: While `cfg_tx` is 1, `lnk_ack_out` and `rd_valid` stay low and strobes on `lnk_stb_in` are ignored. While `cfg_tx` is 0, `lnk_stb_out` and `wr_ready` stay low.
- R7: In the cycle in which `cfg_tx` or `cfg_wide` differs from its value in the previous cycle, all handshake outputs are low. After that cycle, no partially packed or unpacked bytes and no buffered words remain.
- R8: After reset the port holds no words and no partial bytes, so `rd_valid` and `lnk_stb_out` are low.
- R9: Words leave the receiver in the order they entered the transmitter. None is lost or duplicated while `rd_ready` holds the receiver back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for port logic and link |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx | input | 1 | 1 = transmitter, 0 = receiver |
| cfg_wide | input | 1 | 1 = 48-bit words, 0 = 32-bit words |
| wr_valid | input | 1 | Word offered for transmission |
| wr_ready | output | 1 | Transmit side can take a word |
| wr_data | input | 48 | Word to transmit |
| rd_valid | output | 1 | Received word available |
| rd_ready | input | 1 | Consumer takes the received word |
| rd_data | output | 48 | Received word |
| lnk_stb_out | output | 1 | Byte strobe toward the peer |
| lnk_dat_out | output | 8 | Byte toward the peer |
| lnk_ack_in | input | 1 | Peer can accept a byte |
| lnk_stb_in | input | 1 | Byte strobe from the peer |
| lnk_dat_in | input | 8 | Byte from the peer |
| lnk_ack_out | output | 1 | This port can accept a byte |

## Verification
A word accepted on the word side shows up as a strobe on the link from the next cycle on, one byte per cycle while acknowledge stays high. A received word becomes valid in the cycle after its last byte is strobed in. Acknowledge and ready change in the cycle after the buffer count they depend on changes, and the outputs of a configuration change are inactive in the cycle the new value is first present. Stimulus changes just after a rising edge and every port is sampled at the falling edge, so each check sees settled values from the cycle it targets. The scoreboard compares link bytes and output words in arrival order, not at fixed times, so a valid design passes whatever the exact latency. Level checks on acknowledge, ready and valid are made only after enough cycles for the buffers to settle.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam int LP_BYTE_W       = 8;
    localparam int LP_NARROW_BYTES = 4;
    localparam int LP_WIDE_BYTES   = 6;

    typedef struct packed {
        logic tx;
        logic wide;
    } lp_mode_t;

endpackage

// File: rtl/lp_dbuf.sv
module lp_dbuf #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic [1:0]   cnt
);

    typedef struct packed {
        logic [1:0][W-1:0] slot;
        logic              rd;
        logic [1:0]        cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.rd  = 1'b0;
            st_d.cnt = 2'd0;
        end else begin
            if (push)
                st_d.slot[st_q.rd ^ st_q.cnt[0]] = push_data;
            if (pop)
                st_d.rd = ~st_q.rd;
            st_d.cnt = st_q.cnt + 2'(push) - 2'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head = st_q.slot[st_q.rd];
    assign cnt  = st_q.cnt;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt != 2'd2));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != 2'd0));

endmodule

// File: rtl/lp_unpack.sv
module lp_unpack #(
    parameter int BYTE_W       = 8,
    parameter int NARROW_BYTES = 4,
    parameter int WIDE_BYTES   = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         enable,
    input  logic                         wide,
    input  logic                         wr_valid,
    output logic                         wr_ready,
    input  logic [BYTE_W*WIDE_BYTES-1:0] wr_data,
    input  logic                         ack_in,
    output logic                         stb_out,
    output logic [BYTE_W-1:0]            dat_out,
    output logic [1:0]                   cnt
);

    localparam int WORD_W = BYTE_W * WIDE_BYTES;
    localparam int IDX_W  = $clog2(WIDE_BYTES);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } st_t;

    st_t              st_d, st_q;
    logic [WORD_W-1:0] head;
    logic [IDX_W-1:0]  last;
    logic              push, pop;

    assign last     = wide ? IDX_W'(WIDE_BYTES - 1) : IDX_W'(NARROW_BYTES - 1);
    assign wr_ready = enable && (cnt != 2'd2);
    assign stb_out  = enable && (cnt != 2'd0) && ack_in;
    assign dat_out  = stb_out ? head[st_q.idx*BYTE_W +: BYTE_W] : '0;
    assign push     = wr_valid && wr_ready;
    assign pop      = stb_out && (st_q.idx == last);

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.idx = '0;
        else if (stb_out)
            st_d.idx = (st_q.idx == last) ? '0 : st_q.idx + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lp_dbuf #(.W(WORD_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .cnt       (cnt)
    );

    // R2
    tx_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        st_q.idx <= last);

endmodule

// File: rtl/lp_pack.sv
module lp_pack #(
    parameter int BYTE_W       = 8,
    parameter int NARROW_BYTES = 4,
    parameter int WIDE_BYTES   = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         enable,
    input  logic                         wide,
    input  logic                         stb_in,
    input  logic [BYTE_W-1:0]            dat_in,
    output logic                         ack_out,
    output logic                         rd_valid,
    input  logic                         rd_ready,
    output logic [BYTE_W*WIDE_BYTES-1:0] rd_data,
    output logic [1:0]                   cnt
);

    localparam int WORD_W = BYTE_W * WIDE_BYTES;
    localparam int IDX_W  = $clog2(WIDE_BYTES);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [IDX_W-1:0]  idx;
    } st_t;

    st_t               st_d, st_q;
    logic [WORD_W-1:0] word_new;
    logic [IDX_W-1:0]  last;
    logic              take, push, pop;

    assign last     = wide ? IDX_W'(WIDE_BYTES - 1) : IDX_W'(NARROW_BYTES - 1);
    assign ack_out  = enable && (cnt != 2'd2);
    assign rd_valid = enable && (cnt != 2'd0);
    assign take     = stb_in && ack_out;
    assign push     = take && (st_q.idx == last);
    assign pop      = rd_valid && rd_ready;

    always_comb begin
        word_new = st_q.acc;
        word_new[st_q.idx*BYTE_W +: BYTE_W] = dat_in;
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (take) begin
            if (st_q.idx == last) begin
                st_d.acc = '0;
                st_d.idx = '0;
            end else begin
                st_d.acc = word_new;
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lp_dbuf #(.W(WORD_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (push),
        .push_data (word_new),
        .pop       (pop),
        .head      (rd_data),
        .cnt       (cnt)
    );

    // R3
    rx_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        st_q.idx <= last);

endmodule

// File: rtl/lp_link_port.sv
module lp_link_port
    import lp_pkg::*;
#(
    parameter int BYTE_W       = LP_BYTE_W,
    parameter int NARROW_BYTES = LP_NARROW_BYTES,
    parameter int WIDE_BYTES   = LP_WIDE_BYTES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_tx,
    input  logic                         cfg_wide,
    input  logic                         wr_valid,
    output logic                         wr_ready,
    input  logic [BYTE_W*WIDE_BYTES-1:0] wr_data,
    output logic                         rd_valid,
    input  logic                         rd_ready,
    output logic [BYTE_W*WIDE_BYTES-1:0] rd_data,
    output logic                         lnk_stb_out,
    output logic [BYTE_W-1:0]            lnk_dat_out,
    input  logic                         lnk_ack_in,
    input  logic                         lnk_stb_in,
    input  logic [BYTE_W-1:0]            lnk_dat_in,
    output logic                         lnk_ack_out
);

    typedef struct packed {
        lp_mode_t mode;
    } st_t;

    st_t        st_d, st_q;
    logic       flush, tx_en, rx_en;
    logic [1:0] tx_cnt, rx_cnt;

    always_comb begin
        st_d           = st_q;
        st_d.mode.tx   = cfg_tx;
        st_d.mode.wide = cfg_wide;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flush = (cfg_tx != st_q.mode.tx) || (cfg_wide != st_q.mode.wide);
    assign tx_en = cfg_tx && !flush;
    assign rx_en = !cfg_tx && !flush;

    lp_unpack #(
        .BYTE_W(BYTE_W), .NARROW_BYTES(NARROW_BYTES), .WIDE_BYTES(WIDE_BYTES)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flush),
        .enable   (tx_en),
        .wide     (cfg_wide),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_data  (wr_data),
        .ack_in   (lnk_ack_in),
        .stb_out  (lnk_stb_out),
        .dat_out  (lnk_dat_out),
        .cnt      (tx_cnt)
    );

    lp_pack #(
        .BYTE_W(BYTE_W), .NARROW_BYTES(NARROW_BYTES), .WIDE_BYTES(WIDE_BYTES)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flush),
        .enable   (rx_en),
        .wide     (cfg_wide),
        .stb_in   (lnk_stb_in),
        .dat_in   (lnk_dat_in),
        .ack_out  (lnk_ack_out),
        .rd_valid (rd_valid),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .cnt      (rx_cnt)
    );

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_cnt == 2'd0 && rx_cnt == 2'd0));

    // R6
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lnk_ack_out && wr_ready) && !(rd_valid && lnk_stb_out));

endmodule

// File: tb/test_lp_link_port.sv
module test_lp_link_port;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    logic        dut_tx = 1'b0, cfg_wide = 1'b0, direct = 1'b0;
    logic        wv = 1'b0, rr = 1'b0, b_stb = 1'b0;
    logic [47:0] wd = '0;
    logic [7:0]  b_dat = '0;
    logic        mon_en = 1'b0;

    logic        d_wr_ready, d_rd_valid, d_stb_out, d_ack_out;
    logic [47:0] d_rd_data;
    logic [7:0]  d_dat_out;
    logic        p_wr_ready, p_rd_valid, p_stb_out, p_ack_out;
    logic [47:0] p_rd_data;
    logic [7:0]  p_dat_out;

    logic        tx_ready, rx_valid;
    logic [47:0] rx_data;
    assign tx_ready = dut_tx ? d_wr_ready : p_wr_ready;
    assign rx_valid = dut_tx ? p_rd_valid : d_rd_valid;
    assign rx_data  = dut_tx ? p_rd_data  : d_rd_data;

    lp_link_port i_lp_link_port (
        .clk(clk), .rst_n(rst_n), .cfg_tx(dut_tx), .cfg_wide(cfg_wide),
        .wr_valid(dut_tx & wv), .wr_ready(d_wr_ready), .wr_data(wd),
        .rd_valid(d_rd_valid), .rd_ready(~dut_tx & rr), .rd_data(d_rd_data),
        .lnk_stb_out(d_stb_out), .lnk_dat_out(d_dat_out), .lnk_ack_in(p_ack_out),
        .lnk_stb_in(direct ? b_stb : p_stb_out), .lnk_dat_in(direct ? b_dat : p_dat_out),
        .lnk_ack_out(d_ack_out)
    );

    lp_link_port u_peer (
        .clk(clk), .rst_n(rst_n), .cfg_tx(~dut_tx), .cfg_wide(cfg_wide),
        .wr_valid(~dut_tx & wv), .wr_ready(p_wr_ready), .wr_data(wd),
        .rd_valid(p_rd_valid), .rd_ready(dut_tx & rr), .rd_data(p_rd_data),
        .lnk_stb_out(p_stb_out), .lnk_dat_out(p_dat_out), .lnk_ack_in(d_ack_out),
        .lnk_stb_in(d_stb_out), .lnk_dat_in(d_dat_out),
        .lnk_ack_out(p_ack_out)
    );

    logic [47:0] exp_words[$];
    logic [7:0]  exp_bytes[$];

    task automatic chk(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // driver: queues expectations, then offers the word
    task automatic put_word(input logic [47:0] w);
        logic [47:0] m;
        m = cfg_wide ? w : {16'h0, w[31:0]};
        exp_words.push_back(m);
        if (dut_tx)
            for (int i = 0; i < (cfg_wide ? 6 : 4); i++) exp_bytes.push_back(m[i*8 +: 8]);
        @(posedge clk); #1;
        wv = 1'b1; wd = w;
        forever begin
            @(negedge clk);
            if (tx_ready) break;
        end
        @(posedge clk); #1;
        wv = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1;
        b_stb = 1'b1; b_dat = b;
        @(posedge clk); #1;
        b_stb = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic drain();
        while (exp_words.size() != 0 || exp_bytes.size() != 0) @(negedge clk);
        wait_cyc(3);
    endtask

    task automatic set_cfg(input logic tx, input logic wide);
        @(posedge clk); #1;
        dut_tx = tx; cfg_wide = wide;
        wait_cyc(2);
    endtask

    // monitor: compare link bytes and received words against the queues
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            if (dut_tx && d_stb_out) begin
                if (exp_bytes.size() == 0)
                    chk(1'b0, "R1 unexpected byte", {40'h0, d_dat_out}, 48'h0);
                else begin
                    logic [7:0] eb;
                    eb = exp_bytes.pop_front();
                    // R1 R2 R3: byte order on the link
                    chk(d_dat_out == eb && p_ack_out, cfg_wide ? "R3 byte" : "R2 byte",
                        {40'h0, d_dat_out}, {40'h0, eb});
                end
            end
            if (rx_valid && rr) begin
                if (exp_words.size() == 0)
                    chk(1'b0, "R9 unexpected word", rx_data, 48'h0);
                else begin
                    logic [47:0] ew;
                    ew = exp_words.pop_front();
                    // R9 order, R2/R3 packing
                    chk(rx_data == ew, cfg_wide ? "R9 R3 word" : "R9 R2 word", rx_data, ew);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 60000);
            summary();
        end
    end

    initial begin
        // R8 reset state
        wait_cyc(3);
        @(negedge clk);
        chk(!d_rd_valid && !d_stb_out, "R8 in reset", {46'h0, d_rd_valid, d_stb_out}, 48'h0);
        rst_n = 1'b1;
        wait_cyc(3);
        @(negedge clk);
        chk(!d_rd_valid && !d_stb_out && d_ack_out, "R8 after reset",
            {45'h0, d_rd_valid, d_stb_out, d_ack_out}, 48'h1);
        mon_en = 1'b1;
        rr = 1'b1;

        // R2: DUT transmits narrow words, upper bits of wr_data ignored
        set_cfg(1'b1, 1'b0);
        put_word(48'hAAAA_0403_0201);
        put_word(48'h5555_DEAD_BEEF);
        put_word(48'h0000_1234_5678);
        drain();

        // R3: DUT transmits wide words
        set_cfg(1'b1, 1'b1);
        put_word(48'h6655_4433_2211);
        put_word(48'hFEDC_BA98_7654);
        drain();

        // R6: DUT in receive mode keeps its transmit side idle
        set_cfg(1'b0, 1'b1);
        @(negedge clk);
        chk(!d_wr_ready && !d_stb_out, "R6 rx mode tx idle",
            {46'h0, d_wr_ready, d_stb_out}, 48'h0);
        put_word(48'h0102_0304_0506);
        put_word(48'hC0FF_EE00_1177);
        drain();

        // R4 R5 R9: backpressure, DUT receives narrow words
        set_cfg(1'b0, 1'b0);
        rr = 1'b0;
        put_word(48'h0000_1111_1111);
        put_word(48'h0000_2222_2222);
        put_word(48'h0000_3333_3333);
        put_word(48'h0000_4444_4444);
        wait_cyc(20);
        @(negedge clk);
        chk(!d_ack_out, "R4 ack low when two words held", {47'h0, d_ack_out}, 48'h0);
        chk(d_rd_valid, "R4 word offered", {47'h0, d_rd_valid}, 48'h1);
        chk(!p_wr_ready, "R5 tx ready low when two words held", {47'h0, p_wr_ready}, 48'h0);
        chk(!p_stb_out, "R1 no strobe while ack low", {47'h0, p_stb_out}, 48'h0);
        @(posedge clk); #1;
        rr = 1'b1;
        drain();

        // R7: mode change discards buffered words
        rr = 1'b0;
        put_word(48'h0000_AAAA_0001);
        put_word(48'h0000_AAAA_0002);
        wait_cyc(15);
        @(negedge clk);
        chk(d_rd_valid && !d_ack_out, "R4 full before flush",
            {46'h0, d_rd_valid, d_ack_out}, 48'h2);
        exp_words.delete();
        @(posedge clk); #1;
        cfg_wide = 1'b1;
        @(negedge clk);
        chk(!d_ack_out && !d_rd_valid && !p_wr_ready && !p_stb_out, "R7 flush cycle idle",
            {44'h0, d_ack_out, d_rd_valid, p_wr_ready, p_stb_out}, 48'h0);
        @(negedge clk);
        chk(!d_rd_valid && d_ack_out, "R7 buffers cleared",
            {46'h0, d_rd_valid, d_ack_out}, 48'h1);
        @(posedge clk); #1;
        rr = 1'b1;
        put_word(48'h9988_7766_5544);
        drain();

        // R7: partial bytes discarded, driven straight onto the link input
        direct = 1'b1;
        wait_cyc(2);
        send_byte(8'hE1);
        send_byte(8'hE2);
        send_byte(8'hE3);
        set_cfg(1'b0, 1'b0);
        exp_words.push_back(48'h0000_4433_2211);
        send_byte(8'h11);
        send_byte(8'h22);
        send_byte(8'h33);
        send_byte(8'h44);
        wait_cyc(4);
        chk(exp_words.size() == 0, "R7 fresh word after partial discard",
            48'(exp_words.size()), 48'h0);

        // R6: strobes into a transmitting port are ignored
        set_cfg(1'b1, 1'b0);
        @(posedge clk); #1;
        b_stb = 1'b1; b_dat = 8'h5A;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!d_ack_out && !d_rd_valid && !d_stb_out, "R6 tx mode ignores link input",
                {45'h0, d_ack_out, d_rd_valid, d_stb_out}, 48'h0);
        end
        @(posedge clk); #1;
        b_stb = 1'b0;
        direct = 1'b0;
        wait_cyc(2);
        put_word(48'h0000_0D0C_0B0A);
        drain();
        chk(exp_bytes.size() == 0 && !p_rd_valid, "R6 only sent bytes reached peer",
            48'(exp_bytes.size()), 48'h0);

        summary();
    end

endmodule